// File: doc/BRIEF.md
# Predecoded Instruction Cache with Parity

This block is a small direct-mapped instruction cache that holds 64-byte lines and serves one aligned 16-byte fetch block per request. Every stored byte is 10 bits wide: 8 bits of instruction data plus 2 boundary-marker bits that the front end uses to find where instructions start and end. The cache stores these marker bits and returns them unchanged. It does not compute them. A fetch supplies an address. One cycle later the block returns a response strobe, a hit flag, the 16 data bytes and the 32 marker bits.

Lines arrive from the next level through a fill port. The port delivers one 16-byte quarter per cycle over four back-to-back cycles, together with the marker bits for that quarter. Each quarter is protected by one parity bit, which is generated as the quarter is written. A parity mismatch on a fetch is never corrected. The line is dropped and the fetch reports a miss, so the next level supplies a clean copy. A flush input invalidates the whole cache in a single cycle.

Top module: `predecode_icache`

## Requirements
- R1: While reset is asserted and after it is released, no line is valid. The first fetch after reset gives `fetch_rsp_o`=1 with `fetch_hit_o`=0.
- R2: A fetch request at clock edge N raises `fetch_rsp_o` for the cycle after edge N. `fetch_rsp_o` stays low after a cycle with no request. `fetch_hit_o` is never high without `fetch_rsp_o`.
- R3: On a hit, `fetch_data_o` byte k (bits 8k+7:8k) equals byte 16*q+k of the line, where q is address bits [5:4]. Address bits [3:0] have no effect.
- R4: On a hit, `fetch_pd_o` bits 2k+1:2k hold the marker pair that was filled with byte k of the selected quarter.
- R5: A fill consists of four consecutive `fill_valid_i` cycles that carry quarters 0, 1, 2, 3 in that order, with `fill_addr_i` held. A fetch to that line in any of those four cycles misses. The line hits from the cycle after the fourth beat.
- R6: The cache is direct-mapped with 64 lines, indexed by address bits [11:6] and tagged by bits [31:12]. A fetch whose tag differs from the stored tag misses, and a fill replaces the previous occupant of its index.
- R7: A fetch that would hit, but whose quarter fails its parity check, reports a miss and invalidates the line. Other quarters of that line then miss as well. A refill makes the line hit again.
- R8: `flush_i` clears every valid bit at the next edge. A fetch issued in the cycle after a flush misses. A fill whose fourth beat coincides with a flush leaves its line invalid.
- R9: A fill to one line does not disturb hits on other lines, including fetches made while the fill is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all lines |
| fetch_req_i | input | 1 | Fetch request |
| fetch_addr_i | input | 32 | Fetch byte address |
| fetch_rsp_o | output | 1 | Response strobe, one cycle after the request |
| fetch_hit_o | output | 1 | Response is a hit |
| fetch_data_o | output | 128 | 16 instruction bytes, byte 0 in bits 7:0 |
| fetch_pd_o | output | 32 | Two marker bits per byte, byte 0 in bits 1:0 |
| fill_valid_i | input | 1 | Fill beat valid |
| fill_addr_i | input | 32 | Line address of the fill, held for all four beats |
| fill_data_i | input | 128 | Data bytes of the current quarter |
| fill_pd_i | input | 32 | Marker bits of the current quarter |

## Verification
Fetch and fill can occur in the same cycle. The bench drives fill beats and, in a chosen beat, issues a fetch either to the line being written or to a different resident line. The first case must miss in every beat, including the beat that completes the line. The second case must return that other line's data as a hit. Flush and fill completion can also coincide. The bench raises `flush_i` together with the fourth beat and judges the result by a miss on the next fetch to that line, and by hits once the line has been refilled.

// File: rtl/icache_pkg.sv
package icache_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PD_W   = 2;
  localparam int unsigned SLOT_W = BYTE_W + PD_W;
endpackage

// File: rtl/icache_chunk_pack.sv
module icache_chunk_pack
  import icache_pkg::*;
#(
  parameter int unsigned FETCH_BYTES = 16,
  localparam int unsigned DATA_W = FETCH_BYTES * BYTE_W,
  localparam int unsigned PDV_W  = FETCH_BYTES * PD_W,
  localparam int unsigned WORD_W = FETCH_BYTES * SLOT_W
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [PDV_W-1:0]  pd_i,
  output logic [WORD_W-1:0] word_o,
  output logic              par_o
);
  for (genvar k = 0; k < FETCH_BYTES; k++) begin : g_slot
    assign word_o[k*SLOT_W +: SLOT_W] = {pd_i[k*PD_W +: PD_W], data_i[k*BYTE_W +: BYTE_W]};
  end
  assign par_o = ^word_o;
endmodule

// File: rtl/icache_chunk_check.sv
module icache_chunk_check
  import icache_pkg::*;
#(
  parameter int unsigned FETCH_BYTES = 16,
  localparam int unsigned DATA_W = FETCH_BYTES * BYTE_W,
  localparam int unsigned PDV_W  = FETCH_BYTES * PD_W,
  localparam int unsigned WORD_W = FETCH_BYTES * SLOT_W
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              par_i,
  output logic [DATA_W-1:0] data_o,
  output logic [PDV_W-1:0]  pd_o,
  output logic              err_o
);
  for (genvar k = 0; k < FETCH_BYTES; k++) begin : g_slot
    assign data_o[k*BYTE_W +: BYTE_W] = word_i[k*SLOT_W +: BYTE_W];
    assign pd_o[k*PD_W +: PD_W]       = word_i[k*SLOT_W+BYTE_W +: PD_W];
  end
  assign err_o = (^word_i) ^ par_i;
endmodule

// File: rtl/icache_fill_ctrl.sv
module icache_fill_ctrl #(
  parameter int unsigned CHUNKS = 4,
  parameter int unsigned IDX_W  = 6,
  localparam int unsigned CSEL_W = $clog2(CHUNKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_valid_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  output logic [CSEL_W-1:0] beat_o,
  output logic              first_o,
  output logic              last_o,
  output logic              busy_o,
  output logic [IDX_W-1:0]  busy_idx_o
);
  logic [CSEL_W-1:0] cnt_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (fill_valid_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == '0) idx_q <= fill_idx_i;
    end
  end

  assign beat_o     = cnt_q;
  assign first_o    = fill_valid_i && (cnt_q == '0);
  assign last_o     = fill_valid_i && (cnt_q == CSEL_W'(CHUNKS - 1));
  // line counts as in flight from first beat until the last beat retires
  assign busy_o     = fill_valid_i || (cnt_q != '0);
  assign busy_idx_o = (cnt_q == '0) ? fill_idx_i : idx_q;
endmodule

// File: rtl/icache_line_store.sv
module icache_line_store #(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned CHUNKS    = 4,
  parameter int unsigned TAG_W     = 20,
  parameter int unsigned WORD_W    = 160,
  localparam int unsigned IDX_W  = $clog2(NUM_LINES),
  localparam int unsigned CSEL_W = $clog2(CHUNKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [CSEL_W-1:0] wr_chunk_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic              wr_par_i,
  input  logic              set_en_i,
  input  logic [IDX_W-1:0]  set_idx_i,
  input  logic [TAG_W-1:0]  set_tag_i,
  input  logic              clr_a_en_i,
  input  logic [IDX_W-1:0]  clr_a_idx_i,
  input  logic              clr_b_en_i,
  input  logic [IDX_W-1:0]  clr_b_idx_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [CSEL_W-1:0] rd_chunk_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [WORD_W-1:0] rd_word_o,
  output logic              rd_par_o
);
  logic [NUM_LINES-1:0] line_valid;
  logic [TAG_W-1:0]     line_tag  [NUM_LINES];
  logic [CHUNKS-1:0]    line_par  [NUM_LINES];
  logic [WORD_W-1:0]    line_word [NUM_LINES*CHUNKS];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic              valid_q;
    logic [TAG_W-1:0]  tag_q;
    logic [CHUNKS-1:0] par_q;
    logic [WORD_W-1:0] data_q [CHUNKS];
    logic              hit_wr;

    assign hit_wr = wr_en_i && (wr_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         valid_q <= 1'b0;
      else if (flush_i)                                    valid_q <= 1'b0;
      else if (set_en_i && set_idx_i == IDX_W'(i))         valid_q <= 1'b1;
      else if ((clr_a_en_i && clr_a_idx_i == IDX_W'(i)) ||
               (clr_b_en_i && clr_b_idx_i == IDX_W'(i)))   valid_q <= 1'b0;
    end

    always_ff @(posedge clk_i) begin
      if (set_en_i && set_idx_i == IDX_W'(i)) tag_q <= set_tag_i;
    end

    for (genvar c = 0; c < CHUNKS; c++) begin : g_chunk
      always_ff @(posedge clk_i) begin
        if (hit_wr && wr_chunk_i == CSEL_W'(c)) begin
          data_q[c] <= wr_word_i;
          par_q[c]  <= wr_par_i;
        end
      end
      assign line_word[i*CHUNKS+c] = data_q[c];
    end

    assign line_valid[i] = valid_q;
    assign line_tag[i]   = tag_q;
    assign line_par[i]   = par_q;
  end

  assign rd_valid_o = line_valid[rd_idx_i];
  assign rd_tag_o   = line_tag[rd_idx_i];
  assign rd_word_o  = line_word[{rd_idx_i, rd_chunk_i}];
  assign rd_par_o   = line_par[rd_idx_i][rd_chunk_i];
endmodule

// File: rtl/predecode_icache.sv
module predecode_icache
  import icache_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned LINE_BYTES  = 64,
  parameter int unsigned FETCH_BYTES = 16,
  parameter int unsigned NUM_LINES   = 64,
  localparam int unsigned CHUNKS = LINE_BYTES / FETCH_BYTES,
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES),
  localparam int unsigned FOFF_W = $clog2(FETCH_BYTES),
  localparam int unsigned CSEL_W = $clog2(CHUNKS),
  localparam int unsigned IDX_W  = $clog2(NUM_LINES),
  localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int unsigned DATA_W = FETCH_BYTES * BYTE_W,
  localparam int unsigned PDV_W  = FETCH_BYTES * PD_W,
  localparam int unsigned WORD_W = FETCH_BYTES * SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              fetch_rsp_o,
  output logic              fetch_hit_o,
  output logic [DATA_W-1:0] fetch_data_o,
  output logic [PDV_W-1:0]  fetch_pd_o,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic [PDV_W-1:0]  fill_pd_i
);
  logic [IDX_W-1:0]  fetch_idx, fill_idx, busy_idx;
  logic [CSEL_W-1:0] fetch_chunk, fill_beat;
  logic [TAG_W-1:0]  fetch_tag, rd_tag;
  logic              fill_first, fill_last, fill_busy;
  logic [WORD_W-1:0] wr_word, rd_word;
  logic              wr_par, rd_par, rd_valid, rd_err;
  logic [DATA_W-1:0] rd_data;
  logic [PDV_W-1:0]  rd_pd;
  logic              lookup_hit, perr_drop;
  logic              rsp_q, hit_q;
  logic [DATA_W-1:0] data_q;
  logic [PDV_W-1:0]  pd_q;
  logic              unused_addr_bits;

  assign fetch_idx   = fetch_addr_i[OFF_W +: IDX_W];
  assign fetch_chunk = fetch_addr_i[FOFF_W +: CSEL_W];
  assign fetch_tag   = fetch_addr_i[ADDR_W-1 -: TAG_W];
  assign fill_idx    = fill_addr_i[OFF_W +: IDX_W];
  assign unused_addr_bits = ^{fetch_addr_i[FOFF_W-1:0], fill_addr_i[OFF_W-1:0]};

  icache_fill_ctrl #(.CHUNKS(CHUNKS), .IDX_W(IDX_W)) u_fill (
    .clk_i, .rst_ni,
    .fill_valid_i,
    .fill_idx_i (fill_idx),
    .beat_o     (fill_beat),
    .first_o    (fill_first),
    .last_o     (fill_last),
    .busy_o     (fill_busy),
    .busy_idx_o (busy_idx)
  );

  icache_chunk_pack #(.FETCH_BYTES(FETCH_BYTES)) u_pack (
    .data_i (fill_data_i),
    .pd_i   (fill_pd_i),
    .word_o (wr_word),
    .par_o  (wr_par)
  );

  icache_line_store #(
    .NUM_LINES(NUM_LINES), .CHUNKS(CHUNKS), .TAG_W(TAG_W), .WORD_W(WORD_W)
  ) u_store (
    .clk_i, .rst_ni, .flush_i,
    .wr_en_i     (fill_valid_i),
    .wr_idx_i    (fill_idx),
    .wr_chunk_i  (fill_beat),
    .wr_word_i   (wr_word),
    .wr_par_i    (wr_par),
    .set_en_i    (fill_last),
    .set_idx_i   (fill_idx),
    .set_tag_i   (fill_addr_i[ADDR_W-1 -: TAG_W]),
    .clr_a_en_i  (fill_first),
    .clr_a_idx_i (fill_idx),
    .clr_b_en_i  (perr_drop),
    .clr_b_idx_i (fetch_idx),
    .rd_idx_i    (fetch_idx),
    .rd_chunk_i  (fetch_chunk),
    .rd_valid_o  (rd_valid),
    .rd_tag_o    (rd_tag),
    .rd_word_o   (rd_word),
    .rd_par_o    (rd_par)
  );

  icache_chunk_check #(.FETCH_BYTES(FETCH_BYTES)) u_check (
    .word_i (rd_word),
    .par_i  (rd_par),
    .data_o (rd_data),
    .pd_o   (rd_pd),
    .err_o  (rd_err)
  );

  // a line under fill is masked even before its valid bit drops
  assign lookup_hit = rd_valid && (rd_tag == fetch_tag) &&
                      !(fill_busy && busy_idx == fetch_idx);
  assign perr_drop  = fetch_req_i && lookup_hit && rd_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      rsp_q <= fetch_req_i;
      hit_q <= fetch_req_i && lookup_hit && !rd_err;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fetch_req_i) begin
      data_q <= rd_data;
      pd_q   <= rd_pd;
    end
  end

  assign fetch_rsp_o  = rsp_q;
  assign fetch_hit_o  = hit_q;
  assign fetch_data_o = data_q;
  assign fetch_pd_o   = pd_q;
endmodule

// File: rtl/predecode_icache_chk.sv
module predecode_icache_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned NUM_LINES  = 64,
  localparam int unsigned OFF_W = $clog2(LINE_BYTES),
  localparam int unsigned IDX_W = $clog2(NUM_LINES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic              fetch_req_i,
  input logic [ADDR_W-1:0] fetch_addr_i,
  input logic              fill_valid_i,
  input logic [ADDR_W-1:0] fill_addr_i,
  input logic              fetch_rsp_o,
  input logic              fetch_hit_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) reset_quiet_chk: assert (!fetch_rsp_o && !fetch_hit_o);
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_i |=> fetch_rsp_o);

  // R2
  idle_no_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_req_i |=> !fetch_rsp_o);

  // R2
  hit_needs_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_hit_o |-> fetch_rsp_o);

  // R5
  fill_shadow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && fetch_req_i &&
     fill_addr_i[OFF_W +: IDX_W] == fetch_addr_i[OFF_W +: IDX_W]) |=> !fetch_hit_o);

  // R8
  flush_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i ##1 fetch_req_i) |=> !fetch_hit_o);
endmodule

bind predecode_icache predecode_icache_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .NUM_LINES(NUM_LINES)
) u_chk (
  .clk_i, .rst_ni, .flush_i, .fetch_req_i, .fetch_addr_i,
  .fill_valid_i, .fill_addr_i, .fetch_rsp_o, .fetch_hit_o
);

// File: tb/tb_predecode_icache.sv
module tb_predecode_icache;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         flush_i = 1'b0;
  logic         fetch_req_i = 1'b0;
  logic [31:0]  fetch_addr_i = '0;
  logic         fetch_rsp_o, fetch_hit_o;
  logic [127:0] fetch_data_o;
  logic [31:0]  fetch_pd_o;
  logic         fill_valid_i = 1'b0;
  logic [31:0]  fill_addr_i = '0;
  logic [127:0] fill_data_i = '0;
  logic [31:0]  fill_pd_i = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  predecode_icache dut (.*);

  function automatic logic [127:0] exp_data(input logic [31:0] a, input int c, input logic [7:0] s);
    logic [127:0] r;
    for (int k = 0; k < 16; k++)
      r[k*8 +: 8] = (a[13:6] * 8'd37) ^ (8'(c*16 + k) * 8'd11) ^ s;
    return r;
  endfunction

  function automatic logic [31:0] exp_pd(input int c, input logic [7:0] s);
    logic [31:0] r;
    for (int k = 0; k < 16; k++) r[k*2 +: 2] = 2'(k ^ c ^ int'(s));
    return r;
  endfunction

  function automatic logic [3:0] good_par(input logic [31:0] a, input logic [7:0] s);
    logic [3:0] p;
    for (int c = 0; c < 4; c++) p[c] = (^exp_data(a, c, s)) ^ (^exp_pd(c, s));
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [31:0] a, output logic rsp, output logic hit,
                          output logic [127:0] d, output logic [31:0] p);
    @(negedge clk_i);
    fetch_req_i = 1'b1;
    fetch_addr_i = a;
    @(negedge clk_i);
    fetch_req_i = 1'b0;
    rsp = fetch_rsp_o; hit = fetch_hit_o; d = fetch_data_o; p = fetch_pd_o;
  endtask

  task automatic expect_miss(input logic [31:0] a, input string req);
    logic r, h; logic [127:0] d; logic [31:0] p;
    do_fetch(a, r, h, d, p);
    chk(r && !h, req, {r, h}, 2'b10);
  endtask

  // R3 R4: all four quarters of a resident line
  task automatic check_line(input logic [31:0] a, input logic [7:0] s, input string req);
    logic r, h; logic [127:0] d; logic [31:0] p;
    for (int c = 0; c < 4; c++) begin
      do_fetch(a + 32'(c*16 + c), r, h, d, p);
      chk(r && h, req, {r, h}, 2'b11);
      chk(d == exp_data(a, c, s), {req, " R3 data"}, d, exp_data(a, c, s));
      chk(p == exp_pd(c, s), {req, " R4 pd"}, p, exp_pd(c, s));
    end
  endtask

  task automatic fill_line(input logic [31:0] a, input logic [7:0] s, input int probe_beat,
                           input logic [31:0] probe_addr, input bit flush_last, output logic probe_hit);
    bit pend = 0;
    probe_hit = 1'b0;
    for (int b = 0; b < 4; b++) begin
      @(negedge clk_i);
      if (pend) probe_hit = fetch_hit_o;
      pend = 0;
      fetch_req_i  = 1'b0;
      fill_valid_i = 1'b1;
      fill_addr_i  = a;
      fill_data_i  = exp_data(a, b, s);
      fill_pd_i    = exp_pd(b, s);
      flush_i      = flush_last && (b == 3);
      if (b == probe_beat) begin
        fetch_req_i = 1'b1; fetch_addr_i = probe_addr; pend = 1;
      end
    end
    @(negedge clk_i);
    if (pend) probe_hit = fetch_hit_o;
    fill_valid_i = 1'b0; flush_i = 1'b0; fetch_req_i = 1'b0;
  endtask

  localparam logic [31:0] LA = 32'h0000_1040;  // idx 1
  localparam logic [31:0] LB = 32'h0000_3080;  // idx 2
  localparam logic [31:0] LC = 32'h0000_5040;  // idx 1, other tag

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(!fetch_rsp_o && !fetch_hit_o, "R1 reset outputs", {fetch_rsp_o, fetch_hit_o}, 2'b00);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!fetch_rsp_o, "R2 idle no response", fetch_rsp_o, 1'b0);
    expect_miss(32'h0, "R1 first fetch misses");
    expect_miss(LA, "R1 no line valid");
  endtask

  task automatic t_basic;
    logic ph; logic r, h; logic [127:0] d; logic [31:0] p;
    fill_line(LA, 8'h5a, -1, '0, 0, ph);
    check_line(LA, 8'h5a, "R3 basic hit");
    do_fetch(LA + 32'h2f, r, h, d, p);
    chk(h && d == exp_data(LA, 2, 8'h5a), "R3 offset ignored", d, exp_data(LA, 2, 8'h5a));
    @(negedge clk_i);
    chk(!fetch_rsp_o, "R2 response one cycle only", fetch_rsp_o, 1'b0);
  endtask

  task automatic t_tag;
    expect_miss(32'h0000_2040, "R6 tag mismatch");
  endtask

  task automatic t_fill_overlap;
    logic ph;
    fill_line(LB, 8'h11, 1, LB + 32'h10, 0, ph);
    chk(!ph, "R5 fetch during fill beat1", ph, 1'b0);
    fill_line(LB, 8'h22, 2, LA + 32'h30, 0, ph);
    chk(ph, "R9 other line hits during fill", ph, 1'b1);
    fill_line(LB, 8'h33, 3, LB, 0, ph);
    chk(!ph, "R5 fetch during last beat", ph, 1'b0);
    check_line(LB, 8'h33, "R5 valid after fill");
  endtask

  task automatic t_replace;
    logic ph;
    fill_line(LC, 8'h03, -1, '0, 0, ph);
    expect_miss(LA, "R6 old occupant evicted");
    check_line(LC, 8'h03, "R6 new occupant");
    check_line(LB, 8'h33, "R9 neighbour intact");
  endtask

  task automatic t_parity;
    logic ph;
    force dut.u_store.g_line[1].par_q = good_par(LC, 8'h03) ^ 4'b0010;
    @(negedge clk_i);
    release dut.u_store.g_line[1].par_q;
    expect_miss(LC + 32'h10, "R7 parity error misses");
    expect_miss(LC, "R7 line invalidated");
    check_line(LB, 8'h33, "R7 other line intact");
    fill_line(LC, 8'h44, -1, '0, 0, ph);
    check_line(LC, 8'h44, "R7 refill hits");
  endtask

  task automatic t_flush;
    logic ph;
    @(negedge clk_i); flush_i = 1'b1;
    @(negedge clk_i); flush_i = 1'b0;
    expect_miss(LC, "R8 flush line C");
    expect_miss(LB, "R8 flush line B");
    fill_line(LB, 8'h55, -1, '0, 1, ph);
    expect_miss(LB, "R8 flush with last beat");
    fill_line(LB, 8'h66, -1, '0, 0, ph);
    check_line(LB, 8'h66, "R8 refill after flush");
  endtask

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_tag();
    t_fill_overlap();
    t_replace();
    t_parity();
    t_flush();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule